// File: doc/BRIEF.md
# Direction-Masked 4-Bit GPIO Port

A small general-purpose I/O port of four pins, controlled by three registers: a data register, a direction register (a set bit marks an output pin) and a single read-enable bit. A host writes a data value, the port masks it with the current direction and shows the result to an attached serial device through a single-cycle strobe. The device answers in the same cycle, and its answer is what the port stores. A build parameter removes the device. The port then stores the masked value unchanged.

Host reads are gated. While the read-enable bit is clear, every offset reads zero. While it is set, a data read shows only the pins configured as inputs. The register port takes 16-bit writes, which touch one register. It also takes 32-bit writes, which touch two registers: one from the low half of the bus word and one from the high half.

Top module: `gpio4_port`

## Requirements
- R1: After reset the data register is 0000, the direction register is 1111 and the read-enable bit is 0.
- R2: While the read-enable bit is 0, `rdata_o` is 0 at every offset.
- R3: While the read-enable bit is 1, `rdata_o` shows the following, with offsets 0 = data, 1 = direction, 2 = read-enable and 3 = reserved:
  - offset 0: data AND NOT direction;
  - offset 1: direction;
  - offset 2: the read-enable bit in bit 0, with zeros above it;
  - offset 3: 0.
- R4: A data write (offset 0, either width) raises `dev_strobe_o` for exactly that cycle and drives `pins_o` with `wdata_i[3:0]` AND the direction held before that clock edge. With a device present, the data register takes `dev_ret_i` at that edge.
- R5: With `HAS_DEVICE = 0`, a data write stores the masked value, and `dev_ret_i` has no effect.
- R6: A 16-bit write (`wide_i = 0`) does one of the following:
  - at offset 1 it loads direction from bits 3:0;
  - at offset 2 it loads read-enable from bit 0;
  - at offset 3 it changes nothing.
- R7: A 32-bit write at offset 0 does both of the following:
  - it performs the data write of R4 from bits 3:0, masked with the old direction;
  - it loads direction from bits 19:16.
- R8: A 32-bit write at offset 1 loads direction from bits 3:0 and read-enable from bit 16.
- R9: A 32-bit write at offset 2 or 3 changes no register.
- R10: When no data write is in progress, `dev_strobe_o` is 0 and `pins_o` equals the stored data register.
- R11: A data write while the read-enable bit is 0 still updates the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write request |
| wide_i | input | 1 | 1: 32-bit write, 0: 16-bit write |
| addr_i | input | 2 | Register offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 4 | Read data for `addr_i`, combinational |
| pins_o | output | 4 | Value presented to the device |
| dev_strobe_o | output | 1 | One-cycle device handshake on a data write |
| dev_ret_i | input | 4 | Device answer, sampled on the strobe edge |

## Verification
The bench builds two copies side by side from the same stimulus. The first keeps the default `HAS_DEVICE = 1` and is answered by a bench device that inverts two pins. Because the stored data then differs from the masked value, an implementation that bypasses the device is caught. The second copy uses `HAS_DEVICE = 0` and is fed a constant answer on `dev_ret_i`. This copy shows that the answer is ignored and that the masked value is kept. Both use the default four-pin width, so each direction pattern and the old-versus-new direction ordering of a 32-bit data write can be observed.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_CTRL = 2'd2,
    OFS_RSVD = 2'd3
  } gpio_ofs_e;
endpackage

// File: rtl/gpio4_wr_decode.sv
module gpio4_wr_decode #(
  parameter int PIN_W = 4,
  parameter int BUS_W = 32
) (
  input  logic             wr_en_i,
  input  logic             wide_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             data_we_o,
  output logic [PIN_W-1:0] data_val_o,
  output logic             dir_we_o,
  output logic [PIN_W-1:0] dir_val_o,
  output logic             ctrl_we_o,
  output logic             ctrl_val_o
);
  import gpio4_pkg::*;
  localparam int HI_LSB = BUS_W / 2;

  logic [PIN_W-1:0] lo_f, hi_f;
  logic             unused_bits;
  assign lo_f = wdata_i[PIN_W-1:0];
  assign hi_f = wdata_i[HI_LSB+PIN_W-1:HI_LSB];
  assign unused_bits = ^{wdata_i[BUS_W-1:HI_LSB+PIN_W], wdata_i[HI_LSB-1:PIN_W]};

  always_comb begin
    data_we_o  = 1'b0;
    dir_we_o   = 1'b0;
    ctrl_we_o  = 1'b0;
    data_val_o = lo_f;
    dir_val_o  = lo_f;
    ctrl_val_o = wdata_i[0];
    if (wr_en_i) begin
      unique case (gpio_ofs_e'(addr_i))
        OFS_DATA: begin
          data_we_o = 1'b1;
          if (wide_i) begin
            dir_we_o  = 1'b1;
            dir_val_o = hi_f;
          end
        end
        OFS_DIR: begin
          dir_we_o = 1'b1;
          if (wide_i) begin
            ctrl_we_o  = 1'b1;
            ctrl_val_o = wdata_i[HI_LSB];
          end
        end
        OFS_CTRL: ctrl_we_o = !wide_i;
        OFS_RSVD: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio4_dev_link.sv
module gpio4_dev_link #(
  parameter int PIN_W      = 4,
  parameter bit HAS_DEVICE = 1'b1
) (
  input  logic [PIN_W-1:0] masked_i,
  input  logic [PIN_W-1:0] dev_ret_i,
  output logic [PIN_W-1:0] store_o
);
  generate
    if (HAS_DEVICE) begin : g_dev
      assign store_o = dev_ret_i;
    end else begin : g_nodev
      logic unused_ret;
      assign unused_ret = ^dev_ret_i;
      assign store_o    = masked_i;
    end
  endgenerate
endmodule

// File: rtl/gpio4_rd_mux.sv
module gpio4_rd_mux #(
  parameter int PIN_W = 4
) (
  input  logic [1:0]       addr_i,
  input  logic [PIN_W-1:0] data_i,
  input  logic [PIN_W-1:0] dir_i,
  input  logic             ctrl_i,
  output logic [PIN_W-1:0] rdata_o
);
  import gpio4_pkg::*;
  always_comb begin
    rdata_o = '0;
    if (ctrl_i) begin
      unique case (gpio_ofs_e'(addr_i))
        OFS_DATA: rdata_o = data_i & ~dir_i;
        OFS_DIR:  rdata_o = dir_i;
        OFS_CTRL: rdata_o = {{(PIN_W-1){1'b0}}, ctrl_i};
        OFS_RSVD: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port #(
  parameter int PIN_W      = 4,
  parameter int BUS_W      = 32,
  parameter bit HAS_DEVICE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wide_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [PIN_W-1:0] rdata_o,
  output logic [PIN_W-1:0] pins_o,
  output logic             dev_strobe_o,
  input  logic [PIN_W-1:0] dev_ret_i
);
  logic [PIN_W-1:0] data_q, dir_q;
  logic             ctrl_q;
  logic             data_we, dir_we, ctrl_we, ctrl_val;
  logic [PIN_W-1:0] data_val, dir_val, masked, store_val;

  gpio4_wr_decode #(.PIN_W(PIN_W), .BUS_W(BUS_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wide_i    (wide_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .data_we_o (data_we),
    .data_val_o(data_val),
    .dir_we_o  (dir_we),
    .dir_val_o (dir_val),
    .ctrl_we_o (ctrl_we),
    .ctrl_val_o(ctrl_val)
  );

  // mask uses direction before this edge
  assign masked       = data_val & dir_q;
  assign dev_strobe_o = data_we;
  assign pins_o       = data_we ? masked : data_q;

  gpio4_dev_link #(.PIN_W(PIN_W), .HAS_DEVICE(HAS_DEVICE)) u_link (
    .masked_i (masked),
    .dev_ret_i(dev_ret_i),
    .store_o  (store_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '1;
      ctrl_q <= 1'b0;
    end else begin
      if (data_we) data_q <= store_val;
      if (dir_we)  dir_q  <= dir_val;
      if (ctrl_we) ctrl_q <= ctrl_val;
    end
  end

  gpio4_rd_mux #(.PIN_W(PIN_W)) u_rd (
    .addr_i (addr_i),
    .data_i (data_q),
    .dir_i  (dir_q),
    .ctrl_i (ctrl_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/gpio4_port_chk.sv
module gpio4_port_chk #(
  parameter int PIN_W      = 4,
  parameter bit HAS_DEVICE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic             dev_strobe_o,
  input logic [PIN_W-1:0] pins_o,
  input logic [PIN_W-1:0] dev_ret_i,
  input logic [PIN_W-1:0] rdata_o,
  input logic [PIN_W-1:0] data_q,
  input logic [PIN_W-1:0] dir_q,
  input logic             ctrl_q
);
  assert_read_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q |-> rdata_o == '0);

  assert_strobe_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_strobe_o |-> (wr_en_i && addr_i == 2'd0));

  assert_dev_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_DEVICE && dev_strobe_o) |=> data_q == $past(dev_ret_i));

  assert_nodev_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!HAS_DEVICE && dev_strobe_o) |=> data_q == $past(pins_o));

  assert_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_strobe_o |=> $stable(data_q));

  assert_pins_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_strobe_o |-> pins_o == data_q);

  assert_dir_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(dir_q) && $stable(ctrl_q)));
endmodule

bind gpio4_port gpio4_port_chk #(.PIN_W(PIN_W), .HAS_DEVICE(HAS_DEVICE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .dev_strobe_o(dev_strobe_o),
  .pins_o      (pins_o),
  .dev_ret_i   (dev_ret_i),
  .rdata_o     (rdata_o),
  .data_q      (data_q),
  .dir_q       (dir_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/gpio4_port_bench.sv
module gpio4_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wide = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [3:0]  rd_d, pins_d, ret_d, rd_n, pins_n;
  logic        stb_d, stb_n;
  logic [3:0]  ret_n = 4'b1111;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_data [2];
  logic [3:0] m_dir  [2];
  logic       m_ctrl [2];

  always #5 clk = ~clk;

  // bench device: inverts pins 0 and 2
  assign ret_d = pins_d ^ 4'b0101;

  gpio4_port u_gpio4_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wide_i(wide), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_d), .pins_o(pins_d), .dev_strobe_o(stb_d),
    .dev_ret_i(ret_d)
  );

  gpio4_port #(.HAS_DEVICE(1'b0)) u_gpio4_port_nodev (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wide_i(wide), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_n), .pins_o(pins_n), .dev_strobe_o(stb_n),
    .dev_ret_i(ret_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_rd(input int k, input logic [1:0] a);
    if (!m_ctrl[k]) return 4'd0;
    case (a)
      2'd0: return m_data[k] & ~m_dir[k];
      2'd1: return m_dir[k];
      2'd2: return {3'b000, m_ctrl[k]};
      default: return 4'd0;
    endcase
  endfunction

  task automatic cyc(input logic we, input logic wd, input logic [1:0] a,
                     input logic [31:0] v, input string tag);
    logic       s;
    logic [3:0] mk [2];
    @(negedge clk);
    wr_en = we; wide = wd; addr = a; wdata = v;
    #1;
    s = we && (a == 2'd0);
    for (int k = 0; k < 2; k++) mk[k] = v[3:0] & m_dir[k];
    chk(tag, "strobe dev", int'(stb_d), int'(s));
    chk(tag, "strobe nodev", int'(stb_n), int'(s));
    chk(tag, "pins dev", int'(pins_d), int'(s ? mk[0] : m_data[0]));
    chk(tag, "pins nodev", int'(pins_n), int'(s ? mk[1] : m_data[1]));
    chk(tag, "rdata dev", int'(rd_d), int'(exp_rd(0, a)));
    chk(tag, "rdata nodev", int'(rd_n), int'(exp_rd(1, a)));
    if (we) begin
      for (int k = 0; k < 2; k++) begin
        case (a)
          2'd0: begin
            m_data[k] = (k == 0) ? (mk[k] ^ 4'b0101) : mk[k];
            if (wd) m_dir[k] = v[19:16];
          end
          2'd1: begin
            m_dir[k] = v[3:0];
            if (wd) m_ctrl[k] = v[16];
          end
          2'd2: if (!wd) m_ctrl[k] = v[0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 2'(a), 32'hFFFF_FFFF, tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < 2; k++) begin
      m_data[k] = 4'h0; m_dir[k] = 4'hF; m_ctrl[k] = 1'b0;
    end
    addr = 2'd1;
    #23;
    chk("R1", "reset rdata dev", int'(rd_d), 0);
    chk("R1", "reset pins nodev", int'(pins_n), 0);
    rst_n = 1'b1;
    rd_all("R2");
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_0001, "R6");
    rd_all("R1");
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_000A, "R4");
    rd_all("R3");
    cyc(1'b1, 1'b0, 2'd1, 32'h0000_0000, "R6");
    rd_all("R5");
    cyc(1'b1, 1'b1, 2'd1, 32'h0001_0003, "R8");
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_000F, "R4");
    rd_all("R10");
    cyc(1'b1, 1'b1, 2'd0, 32'h000C_0009, "R7");
    rd_all("R7");
    cyc(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFE, "R9");
    cyc(1'b1, 1'b1, 2'd3, 32'hFFFF_FFFF, "R9");
    cyc(1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, "R6");
    rd_all("R9");
    cyc(1'b1, 1'b1, 2'd1, 32'h0000_000F, "R8");
    rd_all("R2");
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_0006, "R11");
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_0002, "R6");
    rd_all("R2");
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_0001, "R6");
    cyc(1'b1, 1'b0, 2'd1, 32'h0000_0000, "R6");
    rd_all("R11");
    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[1], lf[3:2], {12'h0, lf[15:12], 12'h0, lf[7:4]}, "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule